// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block supervises the return of a CAN node from the bus-off state. When the error counters report bus-off, the sequencer raises the node's initialization flag. Raising that flag takes the node off the bus. The sequencer then holds the node there until software releases initialization.

After that release, the sequencer watches the sampled receive line on each bit-time strobe. It counts runs of eleven consecutive recessive bits, which are bus-idle periods. Each completed run is reported as a progress code write, so that software can follow the recovery and spot a bus that is stuck dominant. When the required number of idle runs has been seen, the block pulses a reset to the error counters and lets the node resume normal operation. Software cannot cut the wait short: setting initialization again only pauses the count, and progress already made is kept.

The run length and the number of runs are parameters, with defaults of 11 and 129.

Top module: `can_busoff_recovery`

## Requirements
- R1: After reset, init_o is 1, busy_o, bus_en_o, cnt_reset_o and lec_wr_o are 0, and lec_code_o is 3'b000.
- R2: Outside recovery, a pulse on init_set sets init_o and a pulse on init_clr clears it one cycle later. When both come in the same cycle, set wins. bus_en_o is 1 only when not busy and init_o is 0.
- R3: A rising edge of bus_off while not busy sets init_o and busy_o and drops bus_en_o in the next cycle. This happens even when init_clr is asserted in the same cycle.
- R4: Counting of bit samples starts only after init_o is cleared. While init_o is 1 during recovery, samples are ignored and the progress of both the run and the idle count is kept, so toggling init never shortens recovery.
- R5: Samples count only in cycles with bit_tick high; rx_bit = 1 means recessive and rx_bit = 0 means dominant.
- R6: The eleventh consecutive counted recessive sample gives a one-cycle lec_wr_o pulse with lec_code_o = 3'b101 in the cycle after that strobe. lec_code_o is 3'b000 otherwise, and the run restarts from zero.
- R7: A counted dominant sample restarts the current run from zero but keeps the number of completed idle runs.
- R8: The 129th completed run gives a one-cycle cnt_reset_o pulse in the same cycle as its lec_wr_o pulse. busy_o falls in that cycle, and bus_en_o rises if init_o is 0.
- R9: Edges of bus_off during recovery are ignored, and bit samples outside recovery produce no lec_wr_o or cnt_reset_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe marking a valid bit sample |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive |
| bus_off | input | 1 | Bus-off level from the error counters |
| init_set | input | 1 | Software request to set init |
| init_clr | input | 1 | Software request to clear init |
| init_o | output | 1 | Initialization flag |
| busy_o | output | 1 | Bus-off hold or recovery in progress |
| bus_en_o | output | 1 | Node may take part in bus traffic |
| cnt_reset_o | output | 1 | One-cycle reset for the error counters |
| lec_wr_o | output | 1 | One-cycle progress code write strobe |
| lec_code_o | output | 3 | Progress code, 3'b101 while lec_wr_o is high |

## Verification
The final idle run is the point where two functions meet. In that cycle the progress write for the run and the counter-reset pulse that ends recovery fall together, and busy_o drops at the same edge. The bench drives exactly the required number of idle runs, with a dominant-bit restart and an init pause mixed in. It then samples lec_wr_o, cnt_reset_o and busy_o together on the strobe that completes the last run, and checks that none of the earlier runs raised the reset. A second case in the same cycle is a bus-off edge arriving with a software clear of init. That case is driven from the vector table, which expects init to stay set.

// File: rtl/bor_pkg.sv
package bor_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_HOLD    = 2'd1,
    ST_RECOVER = 2'd2
  } bor_state_t;

  localparam logic [2:0] LEC_NONE = 3'b000;
  localparam logic [2:0] LEC_BIT0 = 3'b101;
endpackage

// File: rtl/bor_counter.sv
// Modulo counter: hit marks the increment that completes LIMIT steps.
module bor_counter #(
  parameter int LIMIT = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] count;

  assign hit = inc && !clr && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc) begin
      if (count == LAST) count <= '0;
      else               count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/bor_ctrl.sv
// Mode sequencer, init flag and registered pulse outputs.
module bor_ctrl
  import bor_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_off,
  input  logic       init_set,
  input  logic       init_clr,
  input  logic       run_hit,
  input  logic       seq_hit,
  output bor_state_t state,
  output logic       init_q,
  output logic       cnt_reset,
  output logic       lec_wr,
  output logic [2:0] lec_code
);
  logic bus_off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_NORMAL;
      init_q    <= 1'b1;
      bus_off_q <= 1'b0;
      cnt_reset <= 1'b0;
      lec_wr    <= 1'b0;
      lec_code  <= LEC_NONE;
    end else begin
      bus_off_q <= bus_off;
      cnt_reset <= 1'b0;
      lec_wr    <= run_hit;
      lec_code  <= run_hit ? LEC_BIT0 : LEC_NONE;

      if (init_set)      init_q <= 1'b1;
      else if (init_clr) init_q <= 1'b0;

      case (state)
        ST_NORMAL: begin
          if (bus_off && !bus_off_q) begin
            state  <= ST_HOLD;
            init_q <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (!init_q) state <= ST_RECOVER;
        end
        ST_RECOVER: begin
          if (seq_hit) begin
            state     <= ST_NORMAL;
            cnt_reset <= 1'b1;
          end
        end
        default: state <= ST_NORMAL;
      endcase
    end
  end
endmodule

// File: rtl/can_busoff_recovery.sv
module can_busoff_recovery
  import bor_pkg::*;
#(
  parameter int RUN_LEN    = 11,
  parameter int SEQ_NEEDED = 129
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_tick,
  input  logic       rx_bit,
  input  logic       bus_off,
  input  logic       init_set,
  input  logic       init_clr,
  output logic       init_o,
  output logic       busy_o,
  output logic       bus_en_o,
  output logic       cnt_reset_o,
  output logic       lec_wr_o,
  output logic [2:0] lec_code_o
);
  bor_state_t state;
  logic init_q, in_rec, rec_tick, run_hit, seq_hit;

  assign in_rec   = (state == ST_RECOVER);
  assign rec_tick = bit_tick && in_rec && !init_q;

  bor_counter #(.LIMIT(RUN_LEN)) u_run (
    .clk (clk),
    .rst (rst),
    .clr (!in_rec || (rec_tick && !rx_bit)),
    .inc (rec_tick && rx_bit),
    .hit (run_hit)
  );

  bor_counter #(.LIMIT(SEQ_NEEDED)) u_seq (
    .clk (clk),
    .rst (rst),
    .clr (!in_rec),
    .inc (run_hit),
    .hit (seq_hit)
  );

  bor_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bus_off   (bus_off),
    .init_set  (init_set),
    .init_clr  (init_clr),
    .run_hit   (run_hit),
    .seq_hit   (seq_hit),
    .state     (state),
    .init_q    (init_q),
    .cnt_reset (cnt_reset_o),
    .lec_wr    (lec_wr_o),
    .lec_code  (lec_code_o)
  );

  assign init_o   = init_q;
  assign busy_o   = (state != ST_NORMAL);
  assign bus_en_o = (state == ST_NORMAL) && !init_q;
endmodule

// File: rtl/bor_checker.sv
module bor_checker (
  input logic       clk,
  input logic       rst,
  input logic       init_o,
  input logic       busy_o,
  input logic       cnt_reset_o,
  input logic       lec_wr_o,
  input logic [2:0] lec_code_o
);
  // R6
  code_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    lec_wr_o |-> (lec_code_o == 3'b101));
  // R6
  write_single_chk: assert property (@(posedge clk) disable iff (rst)
    lec_wr_o |=> !lec_wr_o);
  // R9
  write_in_recovery_chk: assert property (@(posedge clk) disable iff (rst)
    lec_wr_o |-> $past(busy_o));
  // R8
  reset_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_reset_o |-> lec_wr_o);
  // R8
  reset_single_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_reset_o |=> !cnt_reset_o);
  // R8
  exit_by_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> cnt_reset_o);
  // R3
  entry_sets_init_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> init_o);
  // R4
  paused_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && init_o) |=> !lec_wr_o);
endmodule

bind can_busoff_recovery bor_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .init_o      (init_o),
  .busy_o      (busy_o),
  .cnt_reset_o (cnt_reset_o),
  .lec_wr_o    (lec_wr_o),
  .lec_code_o  (lec_code_o)
);

// File: tb/can_busoff_recovery_tb.sv
module can_busoff_recovery_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0, rx_bit = 1'b1, bus_off = 1'b0;
  logic init_set = 1'b0, init_clr = 1'b0;
  logic init_o, busy_o, bus_en_o, cnt_reset_o, lec_wr_o;
  logic [2:0] lec_code_o;

  int checks = 0, errors = 0;
  int wr_total = 0, rst_total = 0;
  logic s_wr, s_rst, s_busy;
  logic [2:0] s_code;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  can_busoff_recovery u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .bus_off(bus_off), .init_set(init_set), .init_clr(init_clr),
    .init_o(init_o), .busy_o(busy_o), .bus_en_o(bus_en_o),
    .cnt_reset_o(cnt_reset_o), .lec_wr_o(lec_wr_o), .lec_code_o(lec_code_o)
  );

  // {bus_off, init_set, init_clr, exp_init, exp_busy, exp_bus_en}
  localparam logic [5:0] VEC [9] = '{
    6'b001_001,  // R2 clear init
    6'b010_100,  // R2 set init
    6'b011_100,  // R2 set wins over clear
    6'b001_001,  // R2 clear again
    6'b101_110,  // R3 bus-off edge beats clear
    6'b101_010,  // R4 software release, still holding
    6'b100_010,  // R4 recovery entered
    6'b110_110,  // R4 pause by set
    6'b101_010   // R4 resume by clear
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_tick = 1'b1;
    rx_bit   = b;
    @(negedge clk);
    bit_tick = 1'b0;
    rx_bit   = 1'b1;
    s_wr = lec_wr_o; s_code = lec_code_o; s_rst = cnt_reset_o; s_busy = busy_o;
    if (s_wr)  wr_total++;
    if (s_rst) rst_total++;
  endtask

  task automatic send_run(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic pulse_init(input logic set, input logic clr);
    @(negedge clk);
    init_set = set; init_clr = clr;
    @(negedge clk);
    init_set = 1'b0; init_clr = 1'b0;
  endtask

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk("R1 init", init_o, 1);
    chk("R1 busy", busy_o, 0);
    chk("R1 bus_en", bus_en_o, 0);
    chk("R1 pulses", {cnt_reset_o, lec_wr_o}, 0);
    chk("R1 code", lec_code_o, 0);

    for (int v = 0; v < 9; v++) begin
      {bus_off, init_set, init_clr} = VEC[v][5:3];
      @(negedge clk);
      init_set = 1'b0; init_clr = 1'b0;
      chk($sformatf("R2/R3/R4 vector %0d", v), {init_o, busy_o, bus_en_o}, VEC[v][2:0]);
    end

    // R5: dominant level without strobe is not counted
    @(negedge clk); rx_bit = 1'b0;
    repeat (4) @(negedge clk);
    rx_bit = 1'b1;
    send_run(10);
    chk("R5 no write before 11th", wr_total, 0);
    send_bit(1'b1);
    chk("R6 write on 11th", s_wr, 1);
    chk("R6 code", s_code, 5);
    @(negedge clk);
    chk("R6 one-cycle write", lec_wr_o, 0);
    chk("R6 code idle", lec_code_o, 0);

    // R7
    send_run(10); send_bit(1'b0); send_run(10);
    chk("R7 dominant restarts run", wr_total, 1);
    send_bit(1'b1);
    chk("R7 count kept", wr_total, 2);

    // R9: bus_off edge during recovery
    @(negedge clk); bus_off = 1'b0;
    @(negedge clk); bus_off = 1'b1;
    @(negedge clk);
    chk("R9 busoff edge ignored", {busy_o, init_o}, 2'b10);

    // R4: pause keeps progress
    send_run(5);
    pulse_init(1'b1, 1'b0);
    send_run(10); send_bit(1'b0); send_run(10);
    chk("R4 paused no write", wr_total, 2);
    pulse_init(1'b0, 1'b1);
    send_run(5);
    chk("R4 run retained, 10 of 11", wr_total, 2);
    send_bit(1'b1);
    chk("R4 write after resume", wr_total, 3);

    // R8: runs 4..129
    bad = 0;
    for (int s = 4; s <= 129; s++) begin
      send_run(10);
      if (s_wr || s_rst || !s_busy) bad++;
      send_bit(1'b1);
      if (!s_wr || s_rst != (s == 129) || s_busy != (s != 129)) bad++;
    end
    chk("R8 run sequence", bad, 0);
    chk("R8 final write and reset together", {s_wr, s_rst}, 2'b11);
    chk("R8 busy drops", s_busy, 0);
    chk("R8 single reset", rst_total, 1);
    chk("R6 total writes", wr_total, 129);
    @(negedge clk);
    bus_off = 1'b0;
    chk("R8 one-cycle reset", cnt_reset_o, 0);
    chk("R8 bus enabled", bus_en_o, 1);

    // R9: samples in normal mode
    send_run(11);
    chk("R9 no write in normal", wr_total, 129);
    chk("R9 no reset in normal", rst_total, 1);

    // R3: new bus-off, R4: hold until release
    @(negedge clk); bus_off = 1'b1;
    @(negedge clk);
    chk("R3 re-entry", {init_o, busy_o, bus_en_o}, 3'b110);
    send_run(11);
    chk("R4 no count while held", wr_total, 129);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule